// File: doc/BRIEF.md
# Windowed Input Power Monitor

This block watches a stream of signed samples and gathers one statistic over a programmable window. The statistic can be the largest magnitude seen, the mean of the squared samples, or a count of samples whose magnitude lies above a threshold. The window length is always a power of two, set by a log2 field.

At the end of each window, the result is moved into a holding register that the host can read. A status flag is raised at the same time, and an interrupt line follows that flag whenever its enable is set.

The window counter can also be switched off. In that case the accumulator runs freely. Each host read strobe takes a snapshot of the current statistic, and the accumulator can optionally be cleared when that read happens. The window timer keeps running and keeps raising the status flag.

Top module: `sig_power_monitor`

## Requirements
- R1: With mode 00 (peak), the holding register receives the largest |x| over the window. The most negative sample counts as its full magnitude.
- R2: With mode 01 (mean), the holding register receives floor(sum of x*x / 2^L), where L is `win_log2`.
- R3: With mode 10 (count), the holding register receives the number of samples with |x| strictly greater than `thresh`, where `thresh` is unsigned.
- R4: With mode 11, the holding register keeps its value at a window end, but the status flag is still set.
- R5: A window is 2^L valid samples, counted from the rise of `mon_en` or from the previous window end. The holding register takes the result on the clock edge that accepts the last sample, and the next window starts from a cleared accumulator.
- R6: `irq_status` is set at each window end whatever the value of `irq_en`. A `rd_strobe` clears it, and a set in the same cycle wins over the clear. `irq` is high only when both `irq_status` and `irq_en` are high.
- R7: While `mon_en` is low, samples leave the holding register unchanged, no status is set, and the timer and accumulator restart.
- R8: With `win_cnt_en` low, a window end does not touch the holding register but still sets the status flag. Each `rd_strobe` copies the current statistic into the holding register.
- R9: With `win_cnt_en` low and `clr_on_read` high, a read clears the accumulator. With `win_cnt_en` high, neither reads nor `clr_on_read` affect the accumulator.
- R10: The accumulator saturates at 2^AW-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitor enable |
| mode_sel | input | 2 | Statistic select: 00 peak, 01 mean, 10 count, 11 none |
| win_cnt_en | input | 1 | Window counter enable; low selects read-snapshot operation |
| clr_on_read | input | 1 | Clear the accumulator on read when the counter is off |
| win_log2 | input | LW | log2 of the window length in samples |
| thresh | input | SW | Unsigned magnitude threshold for count mode |
| irq_en | input | 1 | Interrupt enable |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | SW | Signed sample |
| rd_strobe | input | 1 | Host read strobe |
| hold_val | output | AW | Holding register |
| irq_status | output | 1 | Window-end status flag |
| irq | output | 1 | Gated interrupt |

## Verification
Peak mode is tried in two ways:
- A window whose largest magnitude comes from a negative sample, to separate a magnitude from a signed compare.
- A window that contains the most negative code, to expose sign-extension errors.

Mean mode is tried in two ways:
- Small ramps, where the right shift truncates.
- Alternating ±100, where squaring must hide the sign.

Count mode uses samples that sit exactly at the threshold, one above it, and both signs of each. This tells a strict compare apart from an inclusive one. Free-running operation is tried in several ways:
- Reads with and without clearing.
- Reads while the counter is on, which must be ignored.
- A run of full-scale squares that must stop at all ones instead of wrapping.

// File: rtl/sigmon_pkg.sv
package sigmon_pkg;
  typedef enum logic [1:0] {
    MODE_PEAK = 2'b00,
    MODE_MEAN = 2'b01,
    MODE_THR  = 2'b10,
    MODE_NONE = 2'b11
  } mon_mode_e;
endpackage

// File: rtl/sigmon_window_timer.sv
module sigmon_window_timer #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [LW-1:0] win_log2,
  output logic          win_end
);
  localparam int CW = 1 << LW;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] win_last;

  assign win_last = (CW'(1) << win_log2) - CW'(1);
  assign win_end  = run && step && (cnt_q == win_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (step)      cnt_q <= win_end ? '0 : cnt_q + CW'(1);
  end

  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt_q == '0)); // R5

  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/sigmon_stat_accum.sv
module sigmon_stat_accum
  import sigmon_pkg::*;
#(
  parameter int SW = 14,
  parameter int AW = 32,
  parameter int LW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 step,
  input  mon_mode_e            mode,
  input  logic [SW-1:0]        thresh,
  input  logic [LW-1:0]        win_log2,
  input  logic                 clear,
  input  logic signed [SW-1:0] sample,
  output logic [AW-1:0]        stat_now
);
  localparam int PW = 2 * SW;

  function automatic logic [SW-1:0] f_mag(input logic signed [SW-1:0] x);
    logic [SW-1:0] r;
    r = unsigned'(x);
    if (x[SW-1]) r = ~r + SW'(1);
    return r;
  endfunction

  function automatic logic [AW-1:0] f_sat_add(input logic [AW-1:0] a,
                                              input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[AW] ? '1 : s[AW-1:0];
  endfunction

  logic [SW-1:0] mag;
  logic [PW-1:0] sq;
  logic [AW-1:0] sq_ext;
  logic [AW-1:0] mag_ext;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_next;

  assign mag     = f_mag(sample);
  assign sq      = PW'(mag) * PW'(mag);
  assign mag_ext = {{(AW-SW){1'b0}}, mag};

  generate
    if (AW > PW) begin : g_sq_wide
      assign sq_ext = {{(AW-PW){1'b0}}, sq};
    end else begin : g_sq_fit
      assign sq_ext = sq[AW-1:0];
    end
  endgenerate

  always_comb begin
    acc_next = acc_q;
    if (step) begin
      unique case (mode)
        MODE_PEAK: if (mag_ext > acc_q) acc_next = mag_ext;
        MODE_MEAN: acc_next = f_sat_add(acc_q, sq_ext);
        MODE_THR:  if (mag > thresh) acc_next = f_sat_add(acc_q, AW'(1));
        default:   acc_next = acc_q;
      endcase
    end
  end

  assign stat_now = (mode == MODE_MEAN) ? (acc_next >> win_log2) : acc_next;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) acc_q <= '0;
    else if (clear)     acc_q <= '0;
    else                acc_q <= acc_next;
  end

  AST_PEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && mode == MODE_PEAK) |=> (acc_q >= $past(acc_q))); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && (&acc_q) && (mode == MODE_MEAN || mode == MODE_THR))
    |=> (&acc_q)); // R10

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc_q == '0)); // R7
endmodule

// File: rtl/sig_power_monitor.sv
module sig_power_monitor
  import sigmon_pkg::*;
#(
  parameter int SW = 14,
  parameter int AW = 32,
  parameter int LW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mon_en,
  input  logic [1:0]           mode_sel,
  input  logic                 win_cnt_en,
  input  logic                 clr_on_read,
  input  logic [LW-1:0]        win_log2,
  input  logic [SW-1:0]        thresh,
  input  logic                 irq_en,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_data,
  input  logic                 rd_strobe,
  output logic [AW-1:0]        hold_val,
  output logic                 irq_status,
  output logic                 irq
);
  mon_mode_e     mode;
  logic          step;
  logic          win_end;
  logic          take_win;
  logic          take_rd;
  logic          acc_clear;
  logic [AW-1:0] stat_now;

  assign mode      = mon_mode_e'(mode_sel);
  assign step      = mon_en && smp_valid;
  assign take_win  = win_end && win_cnt_en && (mode != MODE_NONE);
  assign take_rd   = mon_en && !win_cnt_en && rd_strobe && (mode != MODE_NONE);
  assign acc_clear = (win_end && win_cnt_en) ||
                     (mon_en && !win_cnt_en && rd_strobe && clr_on_read);

  sigmon_window_timer #(.LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(mon_en), .step(step),
    .win_log2(win_log2), .win_end(win_end)
  );

  sigmon_stat_accum #(.SW(SW), .AW(AW), .LW(LW)) u_accum (
    .clk(clk), .rst_n(rst_n), .run(mon_en), .step(step), .mode(mode),
    .thresh(thresh), .win_log2(win_log2), .clear(acc_clear),
    .sample(smp_data), .stat_now(stat_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   hold_val <= '0;
    else if (take_win || take_rd) hold_val <= stat_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_status <= 1'b0;
    else if (win_end)   irq_status <= 1'b1;
    else if (rd_strobe) irq_status <= 1'b0;
  end

  assign irq = irq_status && irq_en;

  AST_STATUS_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> irq_status); // R6

  AST_NONE_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NONE) |=> $stable(hold_val)); // R4

  AST_FREE_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_cnt_en && !rd_strobe) |=> $stable(hold_val)); // R8

  AST_OFF_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !irq_status) |=> !irq_status); // R7
endmodule

// File: tb/sig_power_monitor_bench.sv
module sig_power_monitor_bench;
  localparam int CLK_P = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               mon_en = 1'b0;
  logic [1:0]         mode_sel = 2'b00;
  logic               win_cnt_en = 1'b1;
  logic               clr_on_read = 1'b0;
  logic [4:0]         win_log2 = 5'd0;
  logic [13:0]        thresh = 14'd0;
  logic               irq_en = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [13:0] smp_data = '0;
  logic               rd_strobe = 1'b0;
  logic [31:0]        hold_val;
  logic               irq_status;
  logic               irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sig_power_monitor u_sig_power_monitor (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .mode_sel(mode_sel),
    .win_cnt_en(win_cnt_en), .clr_on_read(clr_on_read), .win_log2(win_log2),
    .thresh(thresh), .irq_en(irq_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .rd_strobe(rd_strobe), .hold_val(hold_val),
    .irq_status(irq_status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = v[13:0];
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic restart(input logic cnt, input logic [1:0] m, input int l2, input logic clr);
    @(negedge clk);
    mon_en     = 1'b0;
    win_cnt_en = 1'b1;
    rd_pulse();
    mode_sel    = m;
    win_log2    = l2[4:0];
    clr_on_read = clr;
    win_cnt_en  = cnt;
    @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R6 reset hold", hold_val, 32'd0);
    chk("R6 reset status", {31'd0, irq_status}, 32'd0);
    chk("R6 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_peak();
    restart(1'b1, 2'b00, 2, 1'b0);
    irq_en = 1'b0;
    push(3); push(-9); push(5);
    chk("R5 no end before last sample", {31'd0, irq_status}, 32'd0);
    push(2);
    chk("R1 peak negative max", hold_val, 32'd9);
    chk("R6 status without enable", {31'd0, irq_status}, 32'd1);
    chk("R6 irq gated off", {31'd0, irq}, 32'd0);
    irq_en = 1'b1;
    #1;
    chk("R6 irq gated on", {31'd0, irq}, 32'd1);
    rd_pulse();
    chk("R6 read clears status", {31'd0, irq_status}, 32'd0);
    push(100); push(-8192); push(7); push(0);
    chk("R1 peak most negative", hold_val, 32'd8192);
    irq_en = 1'b0;
  endtask

  task automatic t_mean();
    restart(1'b1, 2'b01, 2, 1'b0);
    push(1); push(2); push(3); push(4);
    chk("R2 mean ramp", hold_val, 32'd30 >> 2);
    push(-100); push(100); push(-100); push(100);
    chk("R2 mean alternating", hold_val, 32'd10000);
  endtask

  task automatic t_thr();
    restart(1'b1, 2'b10, 3, 1'b0);
    thresh = 14'd10;
    push(10); push(11); push(-10); push(-11);
    push(0); push(50); push(-50); push(9);
    chk("R3 strict count", hold_val, 32'd4);
  endtask

  task automatic t_none();
    restart(1'b1, 2'b11, 1, 1'b0);
    push(500); push(-600);
    chk("R4 hold unchanged", hold_val, 32'd4);
    chk("R4 status still set", {31'd0, irq_status}, 32'd1);
  endtask

  task automatic t_off();
    restart(1'b1, 2'b00, 0, 1'b0);
    @(negedge clk);
    mon_en = 1'b0;
    rd_pulse();
    push(1000); push(-2000); push(3);
    chk("R7 hold unchanged when off", hold_val, 32'd4);
    chk("R7 no status when off", {31'd0, irq_status}, 32'd0);
  endtask

  task automatic t_free();
    thresh = 14'd0;
    restart(1'b0, 2'b10, 1, 1'b0);
    push(5); push(6);
    chk("R8 status from timer", {31'd0, irq_status}, 32'd1);
    chk("R8 no hold at window end", hold_val, 32'd4);
    push(7);
    rd_pulse();
    chk("R8 read snapshot", hold_val, 32'd3);
    push(1); push(1);
    rd_pulse();
    chk("R9 no clear keeps count", hold_val, 32'd5);
    clr_on_read = 1'b1;
    rd_pulse();
    chk("R9 clearing read value", hold_val, 32'd5);
    push(-3); push(4);
    rd_pulse();
    chk("R9 count after clear", hold_val, 32'd2);
  endtask

  task automatic t_rd_ignored();
    restart(1'b1, 2'b00, 2, 1'b1);
    push(50);
    rd_pulse();
    push(1); push(1);
    chk("R9 read ignored mid-window", hold_val, 32'd2);
    push(1);
    chk("R9 accumulator kept through read", hold_val, 32'd50);
  endtask

  task automatic t_sat();
    restart(1'b0, 2'b01, 0, 1'b0);
    for (int i = 0; i < 63; i++) push(-8192);
    rd_pulse();
    chk("R10 below limit", hold_val, 32'hFC00_0000);
    push(-8192); push(-8192);
    rd_pulse();
    chk("R10 saturated", hold_val, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_peak();
    t_mean();
    t_thr();
    t_none();
    t_off();
    t_free();
    t_rd_ignored();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule